// File: doc/BRIEF.md
# Round-Robin Multi-Link Output Distributor

This block sits at the edge of the periphery. It takes 44-bit event words from the chip-wide data bus and spreads them over a programmable number of byte-wide output links, from one to eight. Each accepted word goes to the next link in cyclic order. The block skips any link whose queue is nearly full, so a single slow link does not stall the bus. Each link stores its words in a small FIFO. A slicer then sends every word out as six bytes, which feed the line encoder that follows.

The input is a valid/ready stream. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only when every enabled link is nearly full, and `busy` then rises to report congestion to the bus. Each link output is also valid/ready. A byte is presented with `link_valid` and held unchanged until the consumer raises `link_ready`. The link count is read from a plain configuration input. A new count is applied only while every link is completely drained.

Top module: `rr_link_distributor`

## Requirements
- R1: After reset, `in_ready` is 1, `busy` is 0, and no `link_valid` or `link_afull` bit is set. The first word accepted goes to link 0.
- R2: Accepted words go to links 0..N-1 in cyclic order, where N is the active link count. The pointer moves to the link after the one chosen and wraps from N-1 to 0. Links N and above never present a byte.
- R3: The 4-bit `cfg_links` field sets N. The value 0 gives N=1, values 1 to 8 give N equal to the value, and values 9 to 15 give N=8.
- R4: A word leaves its link as 6 bytes, most significant first. The first byte is {4'b0000, word[43:40]}, and byte k (k=1..5) is word[47-8k : 40-8k]. A presented byte stays stable while `link_valid` is high and `link_ready` is low.
- R5: When the pointer lands on a link that is almost full, that link is skipped and the word goes to the next link in cyclic order that is not almost full.
- R6: `link_afull[i]` is high when link i holds 3 or more words queued behind the word it is currently sending. With the consumer stalled, a link therefore absorbs 4 words before it reports almost full.
- R7: `busy` is high, and `in_ready` is low, exactly when every enabled link is almost full. No word is taken while `busy` is high. When one link drains, `busy` falls.
- R8: A change of `cfg_links` takes effect only in a cycle where all link queues and slicers are empty and no word is being accepted. When the count changes, the pointer returns to link 0.
- R9: When a word is accepted by an idle link at clock edge E, its first byte is presented from edge E+1 onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_links | input | 4 | Requested number of active links |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be taken |
| in_word | input | 44 | Event word from the periphery bus |
| busy | output | 1 | All enabled links are congested |
| link_valid | output | 8 | Per-link byte valid |
| link_ready | input | 8 | Per-link byte taken by the consumer |
| link_byte | output | 64 | Per-link byte, link i in bits [8i+7:8i] |
| link_afull | output | 8 | Per-link almost-full flag |

## Verification
`in_ready` and `busy` are combinational in the queue levels, so they change in the same cycle as the push that fills a queue. The first byte of a word bound for an idle link appears one edge after its acceptance. The bench drives every input just after a rising edge and samples every output at the falling edge. The latency check looks at the falling edge after the accept edge, where no byte is expected yet, and then at the falling edge one cycle later, where the first byte must be present. Scenarios with spaced words wait nine or more cycles between pushes so that each link has drained. The expected byte stream for each link is built from the routing rules and compared with a log of the bytes taken at the falling edges.

// File: rtl/rrd_pkg.sv
`timescale 1ns/1ps
package rrd_pkg;
  localparam int BYTE_W = 8;

  function automatic int bytes_for(int width);
    return (width + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/link_fifo.sv
`timescale 1ns/1ps
module link_fifo #(
  parameter int W        = 44,
  parameter int DEPTH    = 4,
  parameter int AF_LEVEL = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         afull
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign afull = (cnt_q >= CW'(AF_LEVEL));
endmodule

// File: rtl/byte_slicer.sv
`timescale 1ns/1ps
module byte_slicer #(
  parameter int WORD_W = 44,
  parameter int BYTES  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_word,
  output logic              src_take,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  input  logic              out_ready,
  output logic              active
);
  localparam int IW  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int PW  = BYTES * 8;

  logic              hold_q;
  logic [WORD_W-1:0] word_q;
  logic [IW-1:0]     idx_q;
  logic [PW-1:0]     padded;
  logic              at_last;

  assign at_last  = (idx_q == IW'(BYTES - 1));
  assign src_take = src_valid && (!hold_q || (out_ready && at_last));
  assign padded   = PW'(word_q);
  assign out_byte = padded[(BYTES - 1 - int'(idx_q)) * 8 +: 8];
  assign out_valid = hold_q;
  assign active    = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      word_q <= '0;
      idx_q  <= '0;
    end else if (src_take) begin
      hold_q <= 1'b1;
      word_q <= src_word;
      idx_q  <= '0;
    end else if (hold_q && out_ready) begin
      if (at_last) hold_q <= 1'b0;
      else         idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
module rr_pick #(
  parameter int N     = 8,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [PTR_W-1:0] start,
  input  logic [CNT_W-1:0] count,
  input  logic [N-1:0]     blocked,
  output logic [PTR_W-1:0] pick,
  output logic             found
);
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(start) + k;
      if (idx >= int'(count)) idx = idx - int'(count);
      if (!found && (k < int'(count)) && !blocked[idx[PTR_W-1:0]]) begin
        found = 1'b1;
        pick  = idx[PTR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rr_link_distributor.sv
`timescale 1ns/1ps
module rr_link_distributor #(
  parameter int WORD_W     = 44,
  parameter int MAX_LINKS  = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int AF_LEVEL   = 3,
  parameter int CFG_W      = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CFG_W-1:0]               cfg_links,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [WORD_W-1:0]              in_word,
  output logic                           busy,
  output logic [MAX_LINKS-1:0]           link_valid,
  input  logic [MAX_LINKS-1:0]           link_ready,
  output logic [MAX_LINKS*rrd_pkg::BYTE_W-1:0] link_byte,
  output logic [MAX_LINKS-1:0]           link_afull
);
  import rrd_pkg::*;

  localparam int BYTES = bytes_for(WORD_W);
  localparam int PTR_W = (MAX_LINKS > 1) ? $clog2(MAX_LINKS) : 1;
  localparam int CNT_W = $clog2(MAX_LINKS + 1);

  logic [CNT_W-1:0]     active_n, want_n;
  logic [PTR_W-1:0]     ptr, pick, nxt;
  logic                 found, accept, all_idle;
  logic [MAX_LINKS-1:0] en_mask, fifo_empty, fifo_afull, slice_active;

  // requested link count, clamped to 1..MAX_LINKS
  always_comb begin
    if (cfg_links == '0)
      want_n = CNT_W'(1);
    else if (int'(cfg_links) > MAX_LINKS)
      want_n = CNT_W'(MAX_LINKS);
    else
      want_n = CNT_W'(cfg_links);
  end

  always_comb begin
    for (int i = 0; i < MAX_LINKS; i++)
      en_mask[i] = (CNT_W'(i) < active_n);
  end

  rr_pick #(.N(MAX_LINKS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_pick (
    .start  (ptr),
    .count  (active_n),
    .blocked(fifo_afull),
    .pick   (pick),
    .found  (found)
  );

  assign in_ready = found;
  assign busy     = !found;
  assign accept   = in_valid && found;
  assign all_idle = &(fifo_empty & ~slice_active);
  assign nxt      = ((CNT_W'(pick) + 1'b1) == active_n) ? '0 : pick + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_n <= CNT_W'(1);
      ptr      <= '0;
    end else if (accept) begin
      ptr <= nxt;
    end else if (all_idle && (want_n != active_n)) begin
      active_n <= want_n;
      ptr      <= '0;
    end
  end

  for (genvar i = 0; i < MAX_LINKS; i++) begin : g_link
    logic [WORD_W-1:0] q_word;
    logic              q_take;

    link_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH), .AF_LEVEL(AF_LEVEL)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (accept && (pick == PTR_W'(i))),
      .din  (in_word),
      .pop  (q_take),
      .dout (q_word),
      .empty(fifo_empty[i]),
      .afull(fifo_afull[i])
    );

    byte_slicer #(.WORD_W(WORD_W), .BYTES(BYTES)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_valid(!fifo_empty[i]),
      .src_word (q_word),
      .src_take (q_take),
      .out_valid(link_valid[i]),
      .out_byte (link_byte[i*BYTE_W +: BYTE_W]),
      .out_ready(link_ready[i]),
      .active   (slice_active[i])
    );
  end

  assign link_afull = fifo_afull;
endmodule

// File: rtl/rrd_checker.sv
`timescale 1ns/1ps
module rrd_checker #(
  parameter int MAX_LINKS = 8,
  parameter int CNT_W     = 4,
  parameter int PTR_W     = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   busy,
  input logic [MAX_LINKS-1:0]   link_valid,
  input logic [MAX_LINKS-1:0]   link_ready,
  input logic [MAX_LINKS*8-1:0] link_byte,
  input logic [MAX_LINKS-1:0]   link_afull,
  input logic [MAX_LINKS-1:0]   en_mask,
  input logic                   all_idle,
  input logic [CNT_W-1:0]       active_n,
  input logic [PTR_W-1:0]       ptr
);
  // R7
  busy_all_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((link_afull | ~en_mask) == '1));

  // R7
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R2
  idle_beyond_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid & ~en_mask) == '0);

  // R2
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(ptr) < active_n);

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_idle |=> $stable(active_n));

  for (genvar i = 0; i < MAX_LINKS; i++) begin : g_hold
    // R4
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid[i] && !link_ready[i]) |=> (link_valid[i] && $stable(link_byte[i*8 +: 8])));
  end
endmodule

bind rr_link_distributor rrd_checker #(
  .MAX_LINKS(MAX_LINKS), .CNT_W(CNT_W), .PTR_W(PTR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .busy      (busy),
  .link_valid(link_valid),
  .link_ready(link_ready),
  .link_byte (link_byte),
  .link_afull(link_afull),
  .en_mask   (en_mask),
  .all_idle  (all_idle),
  .active_n  (active_n),
  .ptr       (ptr)
);

// File: tb/tb_rr_link_distributor.sv
`timescale 1ns/1ps
module tb_rr_link_distributor;
  localparam int WW = 44;
  localparam int NL = 8;
  localparam int MAXB = 512;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [3:0]      cfg_links;
  logic            in_valid;
  logic            in_ready;
  logic [WW-1:0]   in_word;
  logic            busy;
  logic [NL-1:0]   link_valid, link_ready, link_afull;
  logic [NL*8-1:0] link_byte;

  always #2.5 clk = ~clk;

  rr_link_distributor dut (
    .clk(clk), .rst_n(rst_n), .cfg_links(cfg_links),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .busy(busy), .link_valid(link_valid), .link_ready(link_ready),
    .link_byte(link_byte), .link_afull(link_afull)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int wseq   = 0;

  logic [7:0] got   [NL][MAXB];
  int         got_n [NL];
  logic [7:0] exp_b [NL][MAXB];
  int         exp_n [NL];
  int         seen  [NL];

  initial for (int i = 0; i < NL; i++) got_n[i] = 0;

  // byte log, taken at the falling edge where valid and ready are settled
  always @(negedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (rst_n && link_valid[i] && link_ready[i]) begin
        if (got_n[i] < MAXB) got[i][got_n[i]] = link_byte[i*8 +: 8];
        got_n[i] = got_n[i] + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [WW-1:0] mkword();
    logic [WW-1:0] w;
    w = {4'h9 ^ 4'(wseq), 40'h1234567890 + 40'(wseq) * 40'h0F0F0F0F1};
    wseq++;
    return w;
  endfunction

  task automatic expect_word(input int link, input logic [WW-1:0] w);
    logic [47:0] p;
    p = {4'h0, w};
    for (int k = 0; k < 6; k++) begin
      exp_b[link][exp_n[link]] = p[47-8*k -: 8];
      exp_n[link] = exp_n[link] + 1;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [WW-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < NL; i++) begin
      bit ok;
      int bad;
      ok  = (got_n[i] == exp_n[i]);
      bad = -1;
      for (int k = seen[i]; k < exp_n[i] && k < got_n[i]; k++)
        if (bad < 0 && got[i][k] !== exp_b[i][k]) bad = k;
      if (bad >= 0) ok = 1'b0;
      if (!ok && bad >= 0)
        chk(ok, req, $sformatf("link %0d byte %0d", i, bad), got[i][bad], exp_b[i][bad]);
      else
        chk(ok, req, $sformatf("link %0d byte count", i), got_n[i], exp_n[i]);
      seen[i] = exp_n[i];
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(link_valid == '0, "R1", "link_valid", link_valid, 0);
    chk(link_afull == '0, "R1", "link_afull", link_afull, 0);
  endtask

  task automatic t_latency();
    logic [WW-1:0] w;
    cfg_links = 4'd3;
    settle(2);
    w = mkword();
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    #1 in_valid = 1'b0;
    expect_word(0, w);
    @(negedge clk);
    chk(link_valid == '0, "R9", "no byte one half cycle after accept", link_valid, 0);
    @(negedge clk);
    chk(link_valid[0] == 1'b1, "R9", "first byte after one edge", link_valid[0], 1);
    chk(link_byte[7:0] == {4'h0, w[43:40]}, "R4", "padded first byte", link_byte[7:0], {4'h0, w[43:40]});
    settle(10);
    compare("R1");
  endtask

  task automatic t_rr();
    // pointer sits at link 1 after the single word above, N = 3
    for (int k = 0; k < 7; k++) begin
      logic [WW-1:0] w;
      w = mkword();
      push(w);
      expect_word((1 + k) % 3, w);
      settle(9);
    end
    compare("R2");
  endtask

  task automatic t_skip();
    int route [10] = '{0, 1, 0, 1, 0, 1, 0, 1, 1, 1};
    cfg_links = 4'd2;
    settle(2);
    link_ready[0] = 1'b0;
    for (int k = 0; k < 10; k++) begin
      logic [WW-1:0] w;
      w = mkword();
      push(w);
      expect_word(route[k], w);
      settle(9);
      if (k == 4) chk(link_afull[0] == 1'b0, "R6", "afull with 2 queued", link_afull[0], 0);
      if (k == 6) begin
        chk(link_afull[0] == 1'b1, "R6", "afull with 3 queued", link_afull[0], 1);
        chk(link_afull[1] == 1'b0, "R6", "draining link not afull", link_afull[1], 0);
        chk(busy == 1'b0, "R7", "no busy while a link has room", busy, 0);
      end
    end
    link_ready[0] = 1'b1;
    settle(40);
    compare("R5");
  endtask

  task automatic t_busy();
    logic [WW-1:0] w0, w4;
    cfg_links = 4'd1;
    settle(2);
    link_ready[0] = 1'b0;
    w0 = mkword();
    push(w0);
    expect_word(0, w0);
    for (int k = 1; k < 4; k++) begin
      logic [WW-1:0] w;
      w = mkword();
      push(w);
      expect_word(0, w);
    end
    @(negedge clk);
    chk(busy == 1'b1, "R7", "busy after 4 words", busy, 1);
    chk(in_ready == 1'b0, "R7", "in_ready low when all full", in_ready, 0);
    w4 = mkword();
    in_valid = 1'b1;
    in_word  = w4;
    settle(3);
    chk(in_ready == 1'b0, "R7", "word held off while busy", in_ready, 0);
    chk(link_valid[0] && link_byte[7:0] == {4'h0, w0[43:40]}, "R4", "stalled byte held",
        link_byte[7:0], {4'h0, w0[43:40]});
    link_ready[0] = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    expect_word(0, w4);
    settle(40);
    chk(busy == 1'b0, "R7", "busy released after drain", busy, 0);
    compare("R7");
  endtask

  task automatic t_cfg();
    logic [WW-1:0] w;
    link_ready[0] = 1'b0;
    w = mkword(); push(w); expect_word(0, w);
    settle(1);
    cfg_links = 4'd3;
    settle(3);
    w = mkword(); push(w); expect_word(0, w);
    w = mkword(); push(w); expect_word(0, w);
    link_ready[0] = 1'b1;
    settle(40);
    for (int k = 0; k < 3; k++) begin
      w = mkword();
      push(w);
      expect_word(k, w);
      settle(9);
    end
    compare("R8");
  endtask

  task automatic t_clamp();
    logic [WW-1:0] w;
    cfg_links = 4'd12;
    settle(20);
    for (int k = 0; k < 9; k++) begin
      w = mkword();
      push(w);
      expect_word(k % 8, w);
    end
    settle(30);
    compare("R3");
    cfg_links = 4'd0;
    settle(20);
    for (int k = 0; k < 2; k++) begin
      w = mkword();
      push(w);
      expect_word(0, w);
      settle(9);
    end
    compare("R3");
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      exp_n[i] = 0;
      seen[i]  = 0;
    end
    rst_n      = 1'b0;
    cfg_links  = 4'd1;
    in_valid   = 1'b0;
    in_word    = '0;
    link_ready = '1;
    settle(4);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_rr();
    t_skip();
    t_busy();
    t_cfg();
    t_clamp();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule